// File: doc/BRIEF.md
# Sequential Read Bus Master

This block fetches a block of words from consecutive addresses as a master on an AHB5-style bus. A request gives a start address, a word count and a mode. In burst mode the whole block goes out as one incrementing burst of undefined length. In single mode the same block goes out as a string of unrelated single transfers. The two modes move the same data, so a slave that is slower on unsequenced accesses shows the difference on the built-in cycle counter.

A local stall input pauses issue. In burst mode, once the burst has started, a pause is shown as BUSY so the slave keeps its burst context. In single mode, or before the first beat, a pause is shown as IDLE. Read data leaves in address order on a valid/ready stream through a small buffer. The master issues a new beat only when the buffer has room for every beat already in flight. An ERROR response ends the block early and sets a sticky flag. A testbench typically runs blocks of 16 words and compares the counter across the two modes.

Top module: `burst_rd_master`

## Requirements
- R1: In burst mode every accepted beat carries HBURST=INCR (001), HSIZE=word (010) and HWRITE=0. The first beat is NONSEQ (10) and every later beat is SEQ (11). Beat i is at start_addr+4*i.
- R2: In single mode every accepted beat carries HBURST=SINGLE (000) and HTRANS=NONSEQ (10), at start_addr+4*i.
- R3: A stall after the first beat of a burst is shown as BUSY (01), and the burst resumes with SEQ at the next address. A stall before the first beat, any stall in single mode, and every cycle after the final beat are shown as IDLE (00). BUSY never appears in those cases.
- R4: While HREADY is low and HRESP is OKAY, HADDR, HTRANS and HBURST hold their values. Read data is taken only in a cycle with HREADY high.
- R5: Read words leave on rd_data in address order, each equal to the HRDATA of its beat. While rd_valid is high and rd_ready is low, rd_valid and rd_data hold.
- R6: cyc_count counts every cycle from the first cycle that shows the first NONSEQ through the cycle in which the final data phase completes, inclusive. For N beats with no stall and W wait states on each NONSEQ only, the count is N+1+W in burst mode and N+1+N*W in single mode.
- R7: An ERROR response turns HTRANS to IDLE in its first cycle and ends the block after its second cycle, with no further beats. It sets err_flag, which stays high until the next accepted start.
- R8: start is taken only when the block is idle, HREADY is high and word_cnt is nonzero. A start with a zero count, or a start while a block runs, has no effect.
- R9: done pulses for one cycle after the final data phase. From then on busy is low and HTRANS is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a block |
| start_addr | input | ADDR_W | Word-aligned byte address of the first word |
| word_cnt | input | CNT_W | Number of words in the block |
| burst_mode | input | 1 | 1 = one incrementing burst, 0 = single transfers |
| stall | input | 1 | Local request to pause issue |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse when a block ends |
| err_flag | output | 1 | Sticky error indication |
| cyc_count | output | PERF_W | Cycles spent on the last block |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst type |
| hsize | output | 3 | Transfer size, fixed to word |
| hwrite | output | 1 | Direction, fixed to read |
| hready | input | 1 | Bus ready |
| hresp | input | 1 | Bus response, 1 = ERROR |
| hrdata | input | DATA_W | Bus read data |
| rd_valid | output | 1 | Stream word available |
| rd_data | output | DATA_W | Stream word |
| rd_ready | input | 1 | Stream consumer accepts |

## Verification
The bus model in the bench takes an address phase at the same edge the master does, one registered cycle after the master presents it, and it answers from that edge on. Each beat's data therefore appears a fixed number of cycles later: one cycle plus the wait states the model chose. A read word shows on the stream one edge after its data phase completes. done and the final cyc_count value appear one edge after the last data phase. The bench samples all outputs at the falling edge. It waits for the done pulse seen by its monitor before it reads counters or idle state, so no check depends on a guessed latency. Bus and stream checks are made per edge by the monitor against values captured before the edge.

// File: rtl/brm_pkg.sv
// Shared encodings for the sequential read master.
// Assumes the bus transfer-type and burst-type codes of AHB.
package brm_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_t;

    localparam logic [2:0] BURST_SINGLE = 3'b000;
    localparam logic [2:0] BURST_INCR   = 3'b001;

endpackage

// File: rtl/brm_rd_fifo.sv
// Read-data buffer between the bus data phase and the output stream.
// Assumes DEPTH is a power of two and at least 2. The producer never pushes
// when the buffer is full, because issue is gated on lvl_next_o.
module brm_rd_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              valid_o,
    output logic [LVL_W-1:0]  lvl_next_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wp_q, rp_q;
    logic [LVL_W-1:0]  lvl_q;

    // Occupancy after this edge, used by the issue gate.
    always_comb begin
        lvl_next_o = lvl_q + LVL_W'(push_i) - LVL_W'(pop_i);
    end

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[wp_q] <= din_i;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push_i) wp_q <= wp_q + 1'b1;
            if (pop_i)  rp_q <= rp_q + 1'b1;
            lvl_q <= lvl_next_o;
        end
    end

    assign valid_o = (lvl_q != '0);
    assign dout_o  = mem_q[rp_q];

endmodule

// File: rtl/brm_cycle_ctr.sv
// Performance counter: counts from the first cycle that shows the first
// NONSEQ of a block through the cycle of its final data phase.
// Assumes clear_i pulses when a block is accepted, before its first NONSEQ.
module brm_cycle_ctr #(
    parameter int PERF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              nonseq_i,
    input  logic              stop_i,
    output logic [PERF_W-1:0] count_o
);

    logic seen_q, run_q;
    logic counting;

    // A cycle counts if the window is open or this is its opening cycle.
    always_comb begin
        counting = run_q || (!seen_q && nonseq_i);
    end

    // Window control and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            run_q   <= 1'b0;
            count_o <= '0;
        end else if (clear_i) begin
            seen_q  <= 1'b0;
            run_q   <= 1'b0;
            count_o <= '0;
        end else begin
            if (counting) count_o <= count_o + 1'b1;
            if (!seen_q && nonseq_i) begin
                seen_q <= 1'b1;
                run_q  <= !stop_i;
            end else if (stop_i) begin
                run_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/brm_addr_seq.sv
// Address-phase and data-phase sequencer of the read master.
// Shows one transfer type per cycle and advances only on HREADY-high edges.
// It tracks the single outstanding data phase and ends the block normally
// or on ERROR. Assumes a word-aligned start address and a slave that gives
// the two-cycle ERROR response.
module brm_addr_seq
    import brm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 8,
    parameter int BEAT_BYTES = 4,
    parameter int DEPTH      = 4,
    parameter int LVL_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              burst_mode_i,
    input  logic              stall_i,
    input  logic              hready_i,
    input  logic              hresp_i,
    input  logic [LVL_W-1:0]  fifo_next_i,
    output logic [ADDR_W-1:0] haddr_o,
    output logic [1:0]        htrans_o,
    output logic [2:0]        hburst_o,
    output logic              push_o,
    output logic              active_o,
    output logic              done_o,
    output logic              err_o,
    output logic              last_o,
    output logic              take_o
);

    localparam int NEED_W = LVL_W + 2;

    logic              active_q, started_q, mode_q, dphase_q, done_q, err_q;
    logic [CNT_W-1:0]  issue_left_q, data_left_q;
    logic [ADDR_W-1:0] addr_q;
    trans_t            trans_q;
    logic [2:0]        burst_q;

    logic              accept, beat_ok, beat_err, err_first, in_burst, go;
    logic [CNT_W-1:0]  issue_after;
    logic [NEED_W-1:0] need;

    // Edge events decoded from the bus and the pending data phase.
    always_comb begin
        accept      = hready_i && (trans_q == TR_NONSEQ || trans_q == TR_SEQ);
        beat_ok     = hready_i && dphase_q && !hresp_i;
        beat_err    = hready_i && dphase_q && hresp_i;
        err_first   = !hready_i && dphase_q && hresp_i;
        issue_after = issue_left_q - CNT_W'(accept);
        in_burst    = mode_q && (started_q || accept);
        take_o      = start_i && !active_q && hready_i && (count_i != '0);
        last_o      = (beat_ok && data_left_q == CNT_W'(1)) || beat_err;
    end

    // Issue gate: buffer room for every beat in flight plus the next one.
    always_comb begin
        need = NEED_W'(fifo_next_i) + NEED_W'(accept) + NEED_W'(1);
        go   = !stall_i && (need <= NEED_W'(DEPTH));
    end

    // Main sequencing register set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q     <= 1'b0;
            started_q    <= 1'b0;
            mode_q       <= 1'b0;
            dphase_q     <= 1'b0;
            done_q       <= 1'b0;
            err_q        <= 1'b0;
            issue_left_q <= '0;
            data_left_q  <= '0;
            addr_q       <= '0;
            trans_q      <= TR_IDLE;
            burst_q      <= BURST_SINGLE;
        end else begin
            done_q <= 1'b0;
            if (take_o) begin
                active_q     <= 1'b1;
                started_q    <= 1'b0;
                mode_q       <= burst_mode_i;
                err_q        <= 1'b0;
                issue_left_q <= count_i;
                data_left_q  <= count_i;
                addr_q       <= addr_i;
            end else if (active_q && hready_i) begin
                dphase_q <= accept && !last_o;
                if (accept) begin
                    addr_q       <= addr_q + ADDR_W'(BEAT_BYTES);
                    issue_left_q <= issue_after;
                    started_q    <= 1'b1;
                end
                if (beat_ok) data_left_q <= data_left_q - 1'b1;
                if (last_o) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                    trans_q  <= TR_IDLE;
                    if (beat_err) err_q <= 1'b1;
                end else if (issue_after == '0) begin
                    trans_q <= TR_IDLE;
                end else if (go) begin
                    trans_q <= in_burst ? TR_SEQ : TR_NONSEQ;
                    burst_q <= mode_q ? BURST_INCR : BURST_SINGLE;
                end else begin
                    trans_q <= in_burst ? TR_BUSY : TR_IDLE;
                end
            end else if (active_q && err_first) begin
                trans_q      <= TR_IDLE;
                issue_left_q <= '0;
            end
        end
    end

    assign haddr_o  = addr_q;
    assign htrans_o = trans_q;
    assign hburst_o = burst_q;
    assign push_o   = beat_ok;
    assign active_o = active_q;
    assign done_o   = done_q;
    assign err_o    = err_q;

endmodule

// File: rtl/burst_rd_master.sv
// Top of the sequential read master: joins the sequencer, the read buffer
// and the performance counter, and ties off the fixed bus controls.
// Assumes DATA_W is a power-of-two number of bytes and FIFO_DEPTH >= 3 for
// full-rate bursts.
module burst_rd_master
    import brm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int PERF_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    input  logic              burst_mode,
    input  logic              stall,
    output logic              busy,
    output logic              done,
    output logic              err_flag,
    output logic [PERF_W-1:0] cyc_count,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic [2:0]        hburst,
    output logic [2:0]        hsize,
    output logic              hwrite,
    input  logic              hready,
    input  logic              hresp,
    input  logic [DATA_W-1:0] hrdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_ready
);

    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);

    logic             push, pop, last, take;
    logic [LVL_W-1:0] lvl_next;

    // Stream handshake completes a pop.
    always_comb begin
        pop = rd_valid && rd_ready;
    end

    brm_addr_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES),
        .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(start_addr),
        .count_i(word_cnt), .burst_mode_i(burst_mode), .stall_i(stall),
        .hready_i(hready), .hresp_i(hresp), .fifo_next_i(lvl_next),
        .haddr_o(haddr), .htrans_o(htrans), .hburst_o(hburst),
        .push_o(push), .active_o(busy), .done_o(done), .err_o(err_flag),
        .last_o(last), .take_o(take)
    );

    brm_rd_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .din_i(hrdata),
        .pop_i(pop), .dout_o(rd_data), .valid_o(rd_valid),
        .lvl_next_o(lvl_next)
    );

    brm_cycle_ctr #(.PERF_W(PERF_W)) i_ctr (
        .clk(clk), .rst_n(rst_n), .clear_i(take),
        .nonseq_i(htrans == TR_NONSEQ), .stop_i(last), .count_o(cyc_count)
    );

    assign hsize  = 3'($clog2(BEAT_BYTES));
    assign hwrite = 1'b0;

endmodule

// File: rtl/brm_checker.sv
// Protocol checker for burst_rd_master, bound to every instance.
// Assumes the default parameter widths of the top.
module brm_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CNT_W-1:0]  word_cnt,
    input logic              busy,
    input logic              done,
    input logic              err_flag,
    input logic [ADDR_W-1:0] haddr,
    input logic [1:0]        htrans,
    input logic [2:0]        hburst,
    input logic              hready,
    input logic              hresp,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_ready
);

    assert_hold_on_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready && !hresp) |=> ($stable(haddr) && $stable(htrans) && $stable(hburst)));

    assert_seq_only_incr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11) |-> (hburst == 3'b001));

    assert_busy_only_incr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b01) |-> (hburst == 3'b001 && busy));

    assert_stream_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_err_goes_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (htrans == 2'b00));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(start && !busy && hready && word_cnt != '0)) |=> err_flag);

    assert_zero_count_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && word_cnt == '0) |=> !busy);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (htrans == 2'b00 && !busy));

endmodule

bind burst_rd_master brm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_brm_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .word_cnt(word_cnt), .busy(busy),
    .done(done), .err_flag(err_flag), .haddr(haddr), .htrans(htrans),
    .hburst(hburst), .hready(hready), .hresp(hresp), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ready(rd_ready)
);

// File: tb/test_burst_rd_master.sv
module test_burst_rd_master;

    logic        clk, rst_n, start, burst_mode, stall;
    logic [31:0] start_addr;
    logic [7:0]  word_cnt;
    logic        busy, done, err_flag, hwrite, hready, hresp, rd_valid, rd_ready;
    logic [31:0] cyc_count, haddr, hrdata, rd_data;
    logic [1:0]  htrans;
    logic [2:0]  hburst, hsize;

    burst_rd_master i_burst_rd_master (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .word_cnt(word_cnt), .burst_mode(burst_mode), .stall(stall),
        .busy(busy), .done(done), .err_flag(err_flag), .cyc_count(cyc_count),
        .haddr(haddr), .htrans(htrans), .hburst(hburst), .hsize(hsize),
        .hwrite(hwrite), .hready(hready), .hresp(hresp), .hrdata(hrdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready)
    );

    int total = 0, fails = 0;
    int tick = 0;
    // bench knobs
    int ns_wait = 0, force_left = 0, exp_n = 0;
    bit stall_pat = 0, bp_en = 0, err_en = 0;
    logic [31:0] err_addr = 0;
    // log
    logic [31:0] acc_addr [64];
    logic [1:0]  acc_tr   [64];
    logic [2:0]  acc_bu   [64];
    logic [31:0] rx_data  [64];
    int acc_n, rx_n, bad_ctl, busy_cnt, busy_pre, busy_post, idle_mid, hold_viol;
    bit done_seen;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    initial begin
        clk = 0;
        forever #2 clk = ~clk;
    end

    task automatic clear_log();
        acc_n = 0; rx_n = 0; bad_ctl = 0; busy_cnt = 0; busy_pre = 0;
        busy_post = 0; idle_mid = 0; done_seen = 0;
    endtask

    // Bus slave model, stream sink, stall driver and monitor.
    initial begin
        logic        pv, perr, ph_r, ph_e;
        int          pw;
        logic [31:0] pa, p_addr;
        logic [1:0]  p_tr;
        logic [2:0]  p_bu;
        bit          p_ok;
        pv = 0; perr = 0; pw = 0; pa = 0; p_ok = 0;
        ph_r = 1; ph_e = 0; p_addr = 0; p_tr = 0; p_bu = 0;
        hold_viol = 0;
        clear_log();
        hready = 1; hresp = 0; hrdata = 0; rd_ready = 1; stall = 0;
        forever begin
            @(posedge clk);
            tick++;
            if (!rst_n) begin
                pv = 0; pw = 0; p_ok = 0;
                hready <= 1; hresp <= 0; stall <= 0; rd_ready <= 1;
                continue;
            end
            // R4: bus outputs must hold across a wait cycle
            if (p_ok && !ph_r && !ph_e && (haddr !== p_addr || htrans !== p_tr || hburst !== p_bu))
                hold_viol++;
            p_ok = 1; ph_r = hready; ph_e = hresp; p_addr = haddr; p_tr = htrans; p_bu = hburst;
            if (htrans == 2'b01) begin
                busy_cnt++;
                if (acc_n == 0) busy_pre++;
                if (acc_n >= exp_n) busy_post++;
            end
            if (htrans == 2'b00 && hready && busy && acc_n > 0 && acc_n < exp_n) idle_mid++;
            if (done) done_seen = 1;
            if (rd_valid && rd_ready && rx_n < 64) begin
                rx_data[rx_n] = rd_data; rx_n++;
            end
            if (hready) begin
                if (htrans[1]) begin
                    if (acc_n < 64) begin
                        acc_addr[acc_n] = haddr; acc_tr[acc_n] = htrans; acc_bu[acc_n] = hburst;
                    end
                    acc_n++;
                    if (hsize != 3'b010 || hwrite != 1'b0) bad_ctl++;
                    pv = 1; pa = haddr;
                    perr = err_en && (haddr == err_addr);
                    pw = perr ? 1 : ((htrans == 2'b10) ? ns_wait : 0);
                end else begin
                    pv = 0;
                end
            end else if (pw > 0) begin
                pw = pw - 1;
            end
            hready <= !(pv && pw != 0);
            hresp  <= pv && perr;
            hrdata <= pv ? pat(pa) : 32'h0;
            rd_ready <= !bp_en || (tick % 3 == 0);
            stall <= (force_left > 0) || (stall_pat && (tick % 5 < 2));
            if (force_left > 0) force_left--;
        end
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(input logic [31:0] a, input int n, input bit m);
        @(negedge clk);
        clear_log();
        exp_n = n; start_addr = a; word_cnt = 8'(n); burst_mode = m; start = 1;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < 3000 && !done_seen; i++) @(negedge clk);
        for (int i = 0; i < 40 && rx_n < n; i++) @(negedge clk);
    endtask

    // Checks addresses, transfer types and data of a completed block.
    task automatic check_block(input string req, input logic [31:0] a, input int n, input bit m);
        int bad_a, bad_t, bad_d;
        bad_a = 0; bad_t = 0; bad_d = 0;
        for (int i = 0; i < n && i < 64; i++) begin
            if (acc_addr[i] !== a + 32'(4 * i)) bad_a++;
            if (m && (acc_tr[i] !== ((i == 0) ? 2'b10 : 2'b11) || acc_bu[i] !== 3'b001)) bad_t++;
            if (!m && (acc_tr[i] !== 2'b10 || acc_bu[i] !== 3'b000)) bad_t++;
            if (rx_data[i] !== pat(a + 32'(4 * i))) bad_d++;
        end
        check_eq({req, " beats"}, 32'(acc_n), 32'(n));
        check_eq({req, " addresses"}, 32'(bad_a), 0);
        check_eq({req, " types"}, 32'(bad_t), 0);
        check_eq({req, " R5 data"}, 32'(bad_d) + 32'(n - rx_n), 0);
        check_eq({req, " size/write"}, 32'(bad_ctl), 0);
    endtask

    task automatic t_reset();
        check_eq("R9 reset htrans", 32'(htrans), 0);
        check_eq("R9 reset busy", 32'(busy), 0);
        check_eq("R5 reset rd_valid", 32'(rd_valid), 0);
        check_eq("R7 reset err", 32'(err_flag), 0);
        check_eq("R6 reset count", cyc_count, 0);
    endtask

    task automatic t_burst_plain();
        ns_wait = 0;
        launch(32'h0000_1000, 16, 1);
        check_block("R1 burst", 32'h0000_1000, 16, 1);
        check_eq("R6 burst no wait", cyc_count, 17);
        check_eq("R9 idle after done", 32'(htrans), 0);
        check_eq("R9 busy after done", 32'(busy), 0);
    endtask

    task automatic t_mode_compare();
        int c_b;
        ns_wait = 2;
        launch(32'h0000_2000, 16, 1);
        check_block("R1 burst waits", 32'h0000_2000, 16, 1);
        c_b = int'(cyc_count);
        check_eq("R6 burst waits", cyc_count, 19);
        launch(32'h0000_3000, 16, 0);
        check_block("R2 single waits", 32'h0000_3000, 16, 0);
        check_eq("R6 single waits", cyc_count, 49);
        check_eq("R6 single slower", 32'(int'(cyc_count) > c_b), 1);
        check_eq("R4 hold on waits", 32'(hold_viol), 0);
        ns_wait = 0;
    endtask

    task automatic t_stall_burst();
        force_left = 6; stall_pat = 1;
        launch(32'h0000_4000, 16, 1);
        stall_pat = 0;
        check_block("R3 stalled burst", 32'h0000_4000, 16, 1);
        check_eq("R3 busy used", 32'(busy_cnt > 0), 1);
        check_eq("R3 no busy before first", 32'(busy_pre), 0);
        check_eq("R3 no busy after last", 32'(busy_post), 0);
    endtask

    task automatic t_stall_single();
        stall_pat = 1;
        launch(32'h0000_5000, 12, 0);
        stall_pat = 0;
        check_block("R2 stalled single", 32'h0000_5000, 12, 0);
        check_eq("R3 no busy single", 32'(busy_cnt), 0);
        check_eq("R3 idle between singles", 32'(idle_mid > 0), 1);
    endtask

    task automatic t_backpressure();
        bp_en = 1; ns_wait = 1;
        launch(32'h0000_6000, 16, 1);
        bp_en = 0; ns_wait = 0;
        check_block("R5 backpressure", 32'h0000_6000, 16, 1);
        check_eq("R4 hold under backpressure", 32'(hold_viol), 0);
    endtask

    task automatic t_zero_count();
        @(negedge clk);
        clear_log();
        start_addr = 32'h0000_7000; word_cnt = 0; burst_mode = 1; start = 1;
        @(negedge clk);
        start = 0;
        repeat (10) @(negedge clk);
        check_eq("R8 zero count busy", 32'(busy), 0);
        check_eq("R8 zero count no beats", 32'(acc_n), 0);
    endtask

    task automatic t_start_while_busy();
        ns_wait = 1;
        @(negedge clk);
        clear_log();
        exp_n = 8; start_addr = 32'h0000_8000; word_cnt = 8; burst_mode = 1; start = 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        start_addr = 32'h0000_9000; word_cnt = 3; burst_mode = 0; start = 1;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < 3000 && !done_seen; i++) @(negedge clk);
        for (int i = 0; i < 40 && rx_n < 8; i++) @(negedge clk);
        ns_wait = 0;
        check_block("R8 start while busy", 32'h0000_8000, 8, 1);
        repeat (10) @(negedge clk);
        check_eq("R8 no second block", 32'(busy), 0);
    endtask

    task automatic t_error();
        err_en = 1; err_addr = 32'h0000_A00C;
        launch(32'h0000_A000, 8, 1);
        err_en = 0;
        check_eq("R7 done on error", 32'(done_seen), 1);
        check_eq("R7 err flag", 32'(err_flag), 1);
        check_eq("R7 beats stop", 32'(acc_n), 4);
        check_eq("R7 words before error", 32'(rx_n), 3);
        check_eq("R7 idle after error", 32'(htrans), 0);
        repeat (5) @(negedge clk);
        check_eq("R7 flag sticky", 32'(err_flag), 1);
        launch(32'h0000_B000, 4, 1);
        check_block("R7 after error", 32'h0000_B000, 4, 1);
        check_eq("R7 flag cleared by start", 32'(err_flag), 0);
    endtask

    initial begin
        rst_n = 0; start = 0; start_addr = 0; word_cnt = 0; burst_mode = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_burst_plain();
        t_mode_compare();
        t_stall_burst();
        t_stall_single();
        t_backpressure();
        t_zero_count();
        t_start_while_busy();
        t_error();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected=0", tick);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule